// File: doc/BRIEF.md
# Buffer Event Status Register

This block gathers buffer-level events from a network controller's receive and transmit datapaths into one 16-bit status word. Each event arrives as a one-cycle pulse and sets a sticky bit. The events are transmit underrun, lost receive frame, early receive progress and destination address match. A 16-bit configuration input holds per-event enable bits at the same bit positions as the events. A level-sensitive interrupt request stays high while any set event has its enable bit set.

The early-progress event is produced inside the block. A counter restarts on every start-of-frame strobe and counts receive byte strobes. It fires once, when the 128th byte of the frame is accepted. Bytes after that are ignored until the next start-of-frame. Bytes seen before the first start-of-frame are also ignored.

The host reads the whole word through a one-cycle read strobe. The read returns the current value and clears every event bit at the end of that cycle. An event that arrives in the read cycle survives the clear. The low six bits always hold the identifier 0x0C, so the word reads 0x000C when no event is pending.

Top module: `buf_event_reg`

## Requirements
- R1: After reset the read data is 0x000C and the interrupt output is low.
- R2: Bits 5:0 of the read data always equal 6'b001100. Bits 6, 7, 8, 12, 13 and 14 always read zero.
- R3: A transmit underrun pulse sets bit 9 at the next clock edge.
- R4: A lost-frame pulse sets bit 10 at the next clock edge.
- R5: Bit 11 sets on the edge that accepts the 128th byte strobe counted from the last start-of-frame strobe (a byte in the start-of-frame cycle counts as the first). It sets only once per frame.
- R6: An address-match pulse sets bit 15 at the next clock edge.
- R7: A read returns the register value before the clear. When no event arrives in that cycle, all event bits are zero after the read.
- R8: An event pulse in the same cycle as a read is set after that read and shows up on the next read.
- R9: The interrupt output is high exactly when some event bit (9, 10, 11 or 15) and the configuration bit at the same position are both 1. All other configuration bits have no effect.
- R10: Event bits stay set across cycles without a read, and further events accumulate.
- R11: Byte strobes before the first start-of-frame, or fewer than 128 strobes in a frame, never set bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 16 | Interrupt enable bits, same positions as the events |
| tx_underrun_i | input | 1 | Transmit underrun pulse |
| rx_lost_i | input | 1 | Receive frame lost pulse |
| rx_addr_hit_i | input | 1 | Destination address filter passed pulse |
| rx_sof_i | input | 1 | Start of incoming frame strobe |
| rx_byte_i | input | 1 | One received byte strobe |
| rd_i | input | 1 | Host read strobe, clears the events |
| rd_data_o | output | 16 | Status word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a read. The bench raises the read strobe and an event input in the same driven cycle. It expects the first read to miss the new event and the next read to show it. The 128-byte boundary is the other hard case. The bench sends exactly 127 strobes and checks that bit 11 stays clear. One more strobe must set it. A long tail of further strobes must not set it again, and a fresh start-of-frame must re-arm it.

// File: rtl/bevt_pkg.sv
package bevt_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned ID_W      = 6;
  localparam logic [ID_W-1:0] REG_ID = 6'b001100;
  localparam int unsigned NUM_EV    = 4;
  localparam int unsigned POS_UNDR  = 9;
  localparam int unsigned POS_LOST  = 10;
  localparam int unsigned POS_EARLY = 11;
  localparam int unsigned POS_HIT   = 15;
  localparam int unsigned EV_POS [NUM_EV] = '{POS_UNDR, POS_LOST, POS_EARLY, POS_HIT};
  localparam logic [REG_W-1:0] EV_MASK =
    (REG_W'(1) << POS_UNDR) | (REG_W'(1) << POS_LOST) |
    (REG_W'(1) << POS_EARLY) | (REG_W'(1) << POS_HIT);
endpackage

// File: rtl/bevt_rst_sync.sv
module bevt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/bevt_frame_cnt.sv
module bevt_frame_cnt #(
  parameter int unsigned THRESH = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_i,
  input  logic byte_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
  localparam logic [CW-1:0] FULL = CW'(THRESH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] base;
  logic          cnt_en;

  always_comb begin
    base   = sof_i ? '0 : cnt_q;
    fire_o = byte_i && (base == LAST);
    cnt_d  = (byte_i && (base != FULL)) ? base + CW'(1) : base;
    cnt_en = sof_i | byte_i;
  end

  // Counter parks at FULL until the first start-of-frame: no early event before a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: one event per frame, counter never passes its limit
  assert_cnt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !sof_i) |=> (!fire_o || sof_i));
endmodule

// File: rtl/bevt_status.sv
module bevt_status
  import bevt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] cfg_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] word_o,
  output logic             irq_o
);
  logic [REG_W-1:0] ev_q;
  logic [REG_W-1:0] ev_d;
  logic             ev_en;

  always_comb begin
    ev_d  = (rd_i ? set_i : (ev_q | set_i)) & EV_MASK;
    ev_en = rd_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end

  assign word_o = ev_q | {{(REG_W-ID_W){1'b0}}, REG_ID};
  assign irq_o  = |(ev_q & cfg_i & EV_MASK);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (set_i == '0)) |=> (ev_q == '0));
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
  assert_read_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (set_i != '0)) |=> ((ev_q & $past(set_i & EV_MASK)) == $past(set_i & EV_MASK)));
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((word_o & cfg_i & EV_MASK) != '0));
endmodule

// File: rtl/buf_event_reg.sv
module buf_event_reg
  import bevt_pkg::*;
#(
  parameter int unsigned EARLY_BYTES = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_i,
  input  logic        tx_underrun_i,
  input  logic        rx_lost_i,
  input  logic        rx_addr_hit_i,
  input  logic        rx_sof_i,
  input  logic        rx_byte_i,
  input  logic        rd_i,
  output logic [15:0] rd_data_o,
  output logic        irq_o
);
  logic             rst_q_n;
  logic             early_fire;
  logic [NUM_EV-1:0] ev_pulse;
  logic [REG_W-1:0] set_vec;

  bevt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  bevt_frame_cnt #(.THRESH(EARLY_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .sof_i(rx_sof_i), .byte_i(rx_byte_i),
    .fire_o(early_fire)
  );

  assign ev_pulse = {rx_addr_hit_i, early_fire, rx_lost_i, tx_underrun_i};

  for (genvar g = 0; g < REG_W; g++) begin : g_map
    always_comb begin
      set_vec[g] = 1'b0;
      for (int k = 0; k < NUM_EV; k++) begin
        if (EV_POS[k] == g) set_vec[g] = ev_pulse[k];
      end
    end
  end

  bevt_status u_stat (
    .clk(clk), .rst_n(rst_q_n), .set_i(set_vec), .cfg_i(cfg_i), .rd_i(rd_i),
    .word_o(rd_data_o), .irq_o(irq_o)
  );

  assert_undr_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_underrun_i |=> rd_data_o[9]);
  assert_lost_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_lost_i |=> rd_data_o[10]);
  assert_hit_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_addr_hit_i |=> rd_data_o[15]);
  assert_id_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data_o[5:0] == 6'b001100) && (rd_data_o[14:12] == 3'b000) && (rd_data_o[8:6] == 3'b000));
endmodule

// File: tb/buf_event_reg_test.sv
module buf_event_reg_test;
  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_i = '0;
  logic        tx_underrun_i = 1'b0, rx_lost_i = 1'b0, rx_addr_hit_i = 1'b0;
  logic        rx_sof_i = 1'b0, rx_byte_i = 1'b0, rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  buf_event_reg uut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .tx_underrun_i(tx_underrun_i),
    .rx_lost_i(rx_lost_i), .rx_addr_hit_i(rx_addr_hit_i), .rx_sof_i(rx_sof_i),
    .rx_byte_i(rx_byte_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // monitor: every read cycle pops the next expected word
  always @(negedge clk) begin
    if (rd_i) begin
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read actual %h expected none", rd_data_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rd_data_o !== e.val) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", e.tag, rd_data_o, e.val);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [15:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb.push_back(e);
    tick(); rd_i = 1'b1;
    tick(); rd_i = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_cmp++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  task automatic pulse(input int which);
    tick();
    case (which)
      0: tx_underrun_i = 1'b1;
      1: rx_lost_i = 1'b1;
      default: rx_addr_hit_i = 1'b1;
    endcase
    tick();
    tx_underrun_i = 1'b0; rx_lost_i = 1'b0; rx_addr_hit_i = 1'b0;
  endtask

  task automatic bytes(input int n, input bit with_sof);
    tick();
    for (int i = 0; i < n; i++) begin
      rx_byte_i = 1'b1;
      rx_sof_i  = with_sof && (i == 0);
      tick();
    end
    rx_byte_i = 1'b0; rx_sof_i = 1'b0;
  endtask

  task automatic finish_run();
    while (sb.size() != 0) tick();
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk_irq(1'b0, "R1");
    do_read(16'h000C, "R1 reset word");

    // R11: bytes before any start-of-frame are ignored
    bytes(200, 1'b0);
    do_read(16'h000C, "R11 no frame yet");

    pulse(0); do_read(16'h020C, "R3 underrun");
    do_read(16'h000C, "R7 cleared");
    pulse(1); do_read(16'h040C, "R4 lost frame");
    pulse(2); do_read(16'h800C, "R6 address hit");
    do_read(16'h000C, "R2 id only");

    // R5 / R11 frame byte boundary
    bytes(127, 1'b1);
    do_read(16'h000C, "R11 127 bytes");
    bytes(1, 1'b0);
    do_read(16'h080C, "R5 128th byte");
    bytes(300, 1'b0);
    do_read(16'h000C, "R5 once per frame");
    bytes(128, 1'b1);
    do_read(16'h080C, "R5 new frame");

    // R8: event in the read cycle
    tick();
    rd_i = 1'b1; tx_underrun_i = 1'b1;
    begin exp_t e; e.val = 16'h000C; e.tag = "R8 read cycle"; sb.push_back(e); end
    tick();
    rd_i = 1'b0; tx_underrun_i = 1'b0;
    do_read(16'h020C, "R8 survives clear");

    // R10 accumulation
    pulse(0); repeat (10) tick(); pulse(1); repeat (5) tick();
    do_read(16'h060C, "R10 sticky");

    // R9 interrupt masking
    cfg_i = 16'h0200;
    pulse(0);
    chk_irq(1'b1, "R9 underrun enabled");
    cfg_i = 16'hFDFF;
    chk_irq(1'b0, "R9 other enables ignored");
    cfg_i = 16'h8000;
    pulse(2);
    chk_irq(1'b1, "R9 hit enabled");
    do_read(16'h820C, "R9 both set");
    chk_irq(1'b0, "R9 cleared by read");
    cfg_i = 16'h0400;
    pulse(1);
    chk_irq(1'b1, "R9 lost enabled");
    cfg_i = 16'h0800;
    chk_irq(1'b0, "R9 early not pending");
    bytes(128, 1'b1);
    chk_irq(1'b1, "R9 early enabled");
    do_read(16'h0C0C, "R9 lost and early");
    cfg_i = 16'h0000;

    finish_run();
  end
endmodule